// File: doc/BRIEF.md
# Two-Thread Shared Scheduling Queue

This block holds up to twelve pending operations that belong to two logical threads and hands them out for issue as one merged stream. Each slot holds an opaque payload, the thread tag of its owner and an issuable flag. New work arrives on a valid/ready insert port tagged with its thread. Work leaves on a valid/ready issue port that always offers the oldest issuable slot, whatever thread owns it.

The point of the block is fairness on the insert side. Under the shared policy either thread may use any free slot, but neither thread may hold more than half the slots. Under the halves policy the low six slots serve thread 0 only and the high six serve thread 1 only. A solo-mode pin drops both limits so that a lone thread can use the whole queue. A per-thread flush pin empties one thread's slots in a single cycle.

Back-pressure rules: an insert is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` depends combinationally on `in_tid`. An issue is taken when `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered slot stays in the queue. A slot is marked issuable either at insert, or later through `wake_valid` with its slot index.

Top module: `tsq_top`

## Requirements
- R1: After reset the queue is empty: `out_valid`=0, `full`=2'b00, and `in_ready`=1 for both threads.
- R2: Under the shared policy (`part_halves`=0, `solo`=0), a thread that holds 6 slots has its `full` bit set and its `in_ready` low, while the other thread still accepts inserts.
- R3: Under the shared policy, an insert goes to the lowest-numbered free slot among all twelve, whatever its owner's thread. Slot indices run 0 to 11.
- R4: Under the halves policy (`part_halves`=1, `solo`=0), thread 0 inserts go to the lowest free slot among 0..5 and thread 1 inserts go to the lowest free slot among 6..11. A thread whose half is used up reads `full`.
- R5: With `solo`=1, no cap and no halves apply. A thread's `full` bit rises only when all 12 slots are in use.
- R6: The issue port offers the issuable slot that was inserted earliest, ignoring thread tags. `out_tid` and `out_payload` are that slot's contents.
- R7: A slot inserted with `in_issuable`=0 is not offered until `wake_valid` is pulsed with its index. A wake that names an empty slot has no effect.
- R8: A one-cycle pulse on `flush[t]` removes every slot tagged t. The other thread's slots and their order are kept. The freed room shows in `full[t]` on the next cycle. Inserts for t are refused while `flush[t]` is high.
- R9: An insert and an issue in the same cycle both take effect. Per-thread occupancy reflects both changes.
- R10: An insert offered while `in_ready` is low stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| part_halves | input | 1 | 0 = shared policy with per-thread cap, 1 = fixed halves |
| solo | input | 1 | Single-thread mode, removes all limits |
| in_valid | input | 1 | Insert request |
| in_ready | output | 1 | Insert accepted for thread `in_tid` |
| in_tid | input | 1 | Thread tag of the insert |
| in_issuable | input | 1 | Slot is issuable on arrival |
| in_payload | input | 16 | Opaque payload |
| wake_valid | input | 1 | Mark one slot issuable |
| wake_idx | input | 4 | Slot index to mark |
| flush | input | 2 | Per-thread flush, bit t clears thread t |
| out_valid | output | 1 | An issuable slot is offered |
| out_ready | input | 1 | Consumer takes the offered slot |
| out_tid | output | 1 | Thread tag of the offered slot |
| out_payload | output | 16 | Payload of the offered slot |
| full | output | 2 | Per-thread no-room indication |

## Verification
A wrong occupancy counter shows up at the insert port: `full` or `in_ready` flips one insert too early or too late. The bench sees it on the first insert that crosses the cap. A corrupted age stamp shows up as a reordered drain, visible at `out_payload` on the first issue after the fault. A wrong slot choice or half boundary is made visible through wake pulses: waking the expected index either does or does not raise `out_valid` on the next cycle. A flush that leaves behind a slot shows up as a stale payload, or as a `full` bit that stays high one cycle after the pulse.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int TSQ_THREADS = 2;

  typedef enum logic {
    POL_SHARED = 1'b0,
    POL_HALVES = 1'b1
  } tsq_policy_e;
endpackage

// File: rtl/tsq_alloc.sv
module tsq_alloc #(
  parameter int DEPTH = 12,
  parameter int CAP   = DEPTH / 2,
  localparam int IW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DEPTH-1:0]     used,
  input  tsq_pkg::tsq_policy_e policy,
  input  logic                 solo,
  input  logic [OW-1:0]        occ [tsq_pkg::TSQ_THREADS],
  output logic [IW-1:0]        slot [tsq_pkg::TSQ_THREADS],
  output logic [tsq_pkg::TSQ_THREADS-1:0] full
);
  import tsq_pkg::*;

  for (genvar t = 0; t < TSQ_THREADS; t++) begin : g_thr
    logic [DEPTH-1:0] elig;
    logic             found;

    always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
        if (solo || policy == POL_SHARED) elig[i] = 1'b1;
        else if (t == 0)                  elig[i] = (i < HALF);
        else                              elig[i] = (i >= HALF);
      end
    end

    always_comb begin
      found   = 1'b0;
      slot[t] = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (elig[i] && !used[i]) begin
          found   = 1'b1;
          slot[t] = IW'(i);
        end
      end
    end

    assign full[t] = !found ||
                     (!solo && policy == POL_SHARED && occ[t] >= OW'(CAP));

    AST_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      !full[t] |-> !used[slot[t]]); // R3
  end
endmodule

// File: rtl/tsq_select.sv
module tsq_select #(
  parameter int DEPTH = 12,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] cand,
  input  logic [IW-1:0]    stamp [DEPTH],
  output logic             pick_valid,
  output logic [IW-1:0]    pick_idx
);
  logic [IW-1:0] best;

  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    best       = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!pick_valid || stamp[i] < best)) begin
        pick_valid = 1'b1;
        pick_idx   = IW'(i);
        best       = stamp[i];
      end
    end
  end

  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> cand[pick_idx]); // R7
  AST_PICK_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |-> pick_valid); // R6
endmodule

// File: rtl/tsq_top.sv
module tsq_top #(
  parameter int DEPTH = 12,
  parameter int CAP   = DEPTH / 2,
  parameter int PAY_W = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             part_halves,
  input  logic             solo,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_tid,
  input  logic             in_issuable,
  input  logic [PAY_W-1:0] in_payload,
  input  logic             wake_valid,
  input  logic [IW-1:0]    wake_idx,
  input  logic [1:0]       flush,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_tid,
  output logic [PAY_W-1:0] out_payload,
  output logic [1:0]       full
);
  import tsq_pkg::*;

  logic [DEPTH-1:0] vld_q, rdy_q, tid_q;
  logic [PAY_W-1:0] pay_q   [DEPTH];
  logic [IW-1:0]    stamp_q [DEPTH];
  logic [OW-1:0]    occ_q   [TSQ_THREADS];

  logic [DEPTH-1:0] hit_flush, cand, removed;
  logic [IW-1:0]    slot [TSQ_THREADS];
  logic [IW-1:0]    sel_idx, ins_idx;
  logic             sel_valid, deq_fire, ins_fire;
  logic [OW-1:0]    surv_cnt;
  logic [IW-1:0]    older_gone [DEPTH];
  logic [DEPTH-1:0] own0, own1;
  tsq_policy_e      policy;

  assign policy = part_halves ? POL_HALVES : POL_SHARED;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit_flush[i] = vld_q[i] && flush[tid_q[i]];
      cand[i]      = vld_q[i] && rdy_q[i] && !hit_flush[i];
    end
  end

  tsq_alloc #(.DEPTH(DEPTH), .CAP(CAP)) u_alloc (
    .clk(clk), .rst_n(rst_n), .used(vld_q), .policy(policy), .solo(solo),
    .occ(occ_q), .slot(slot), .full(full)
  );

  tsq_select #(.DEPTH(DEPTH)) u_select (
    .clk(clk), .rst_n(rst_n), .cand(cand), .stamp(stamp_q),
    .pick_valid(sel_valid), .pick_idx(sel_idx)
  );

  assign out_valid   = sel_valid;
  assign out_tid     = tid_q[sel_idx];
  assign out_payload = pay_q[sel_idx];
  assign deq_fire    = sel_valid && out_ready;
  assign in_ready    = !full[in_tid] && !flush[in_tid];
  assign ins_fire    = in_valid && in_ready;
  assign ins_idx     = slot[in_tid];

  // Age renumbering: survivors close the gaps left by removed slots.
  always_comb begin
    surv_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      removed[i] = hit_flush[i] || (deq_fire && sel_idx == IW'(i));
      if (vld_q[i] && !removed[i]) surv_cnt = surv_cnt + OW'(1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      older_gone[i] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (removed[j] && stamp_q[j] < stamp_q[i])
          older_gone[i] = older_gone[i] + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rdy_q <= '0;
      tid_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pay_q[i]   <= '0;
        stamp_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (removed[i]) begin
          vld_q[i] <= 1'b0;
        end else if (vld_q[i]) begin
          stamp_q[i] <= stamp_q[i] - older_gone[i];
          if (wake_valid && wake_idx == IW'(i)) rdy_q[i] <= 1'b1;
        end
      end
      if (ins_fire) begin
        vld_q[ins_idx]   <= 1'b1;
        rdy_q[ins_idx]   <= in_issuable;
        tid_q[ins_idx]   <= in_tid;
        pay_q[ins_idx]   <= in_payload;
        stamp_q[ins_idx] <= IW'(surv_cnt);
      end
    end
  end

  for (genvar t = 0; t < TSQ_THREADS; t++) begin : g_occ
    logic add, sub;
    assign add = ins_fire && in_tid == 1'(t);
    assign sub = deq_fire && tid_q[sel_idx] == 1'(t);
    always_ff @(posedge clk) begin
      if (!rst_n)        occ_q[t] <= '0;
      else if (flush[t]) occ_q[t] <= '0;
      else               occ_q[t] <= occ_q[t] + OW'(add) - OW'(sub);
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      own0[i] = vld_q[i] && !tid_q[i];
      own1[i] = vld_q[i] &&  tid_q[i];
    end
  end

  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !solo && !part_halves) |-> occ_q[in_tid] < OW'(CAP)); // R2
  AST_HALF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && part_halves && !solo) |->
      (in_tid ? (ins_idx >= IW'(HALF)) : (ins_idx < IW'(HALF)))); // R4
  AST_FLUSH0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush[0] |=> own0 == '0); // R8
  AST_FLUSH1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush[1] |=> own1 == '0); // R8
  AST_OCC0_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q[0] == OW'($countones(own0))); // R9
  AST_OCC1_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q[1] == OW'($countones(own1))); // R9
  AST_NO_STORE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !deq_fire && flush == 2'b00) |=> $stable(vld_q)); // R10
endmodule

// File: tb/tsq_top_tb_top.sv
module tsq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        part_halves, solo;
  logic        in_valid, in_tid, in_issuable, in_ready;
  logic [15:0] in_payload;
  logic        wake_valid;
  logic [3:0]  wake_idx;
  logic [1:0]  flush;
  logic        out_valid, out_ready, out_tid;
  logic [15:0] out_payload;
  logic [1:0]  full;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tsq_top dut_i (
    .clk(clk), .rst_n(rst_n), .part_halves(part_halves), .solo(solo),
    .in_valid(in_valid), .in_ready(in_ready), .in_tid(in_tid),
    .in_issuable(in_issuable), .in_payload(in_payload),
    .wake_valid(wake_valid), .wake_idx(wake_idx), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_tid(out_tid),
    .out_payload(out_payload), .full(full)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start(logic halves, logic one);
    part_halves = halves; solo = one;
    in_valid = 0; in_tid = 0; in_issuable = 0; in_payload = '0;
    wake_valid = 0; wake_idx = '0; flush = '0; out_ready = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic enq(logic t, logic [15:0] p, logic rdy, output logic acc);
    in_valid = 1; in_tid = t; in_payload = p; in_issuable = rdy;
    #1 acc = in_ready;
    @(posedge clk); #1 in_valid = 0;
  endtask

  task automatic deq_expect(string req, logic [15:0] p, logic t);
    out_ready = 1;
    #1;
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, {16'd0, out_payload}, {16'd0, p});
    check(req, {31'd0, out_tid}, {31'd0, t});
    @(posedge clk); #1 out_ready = 0;
  endtask

  task automatic wake(logic [3:0] idx);
    wake_valid = 1; wake_idx = idx;
    @(posedge clk); #1 wake_valid = 0;
  endtask

  task automatic t_reset();
    start(0, 0);
    #1;
    check("R1 out_valid", {31'd0, out_valid}, 0);
    check("R1 full", {30'd0, full}, 0);
    in_tid = 0; #1 check("R1 ready t0", {31'd0, in_ready}, 1);
    in_tid = 1; #1 check("R1 ready t1", {31'd0, in_ready}, 1);
  endtask

  task automatic t_cap();
    logic a;
    start(0, 0);
    for (int k = 0; k < 6; k++) begin
      enq(0, 16'h100 + 16'(k), 1, a);
      check("R2 accept", {31'd0, a}, 1);
    end
    check("R2 full", {30'd0, full}, 2'b01);
    enq(0, 16'h1FF, 1, a);
    check("R2 refused", {31'd0, a}, 0);
    enq(1, 16'h200, 1, a);
    check("R2 other thread", {31'd0, a}, 1);
    for (int k = 0; k < 6; k++) deq_expect("R10 drain", 16'h100 + 16'(k), 0);
    deq_expect("R10 drain", 16'h200, 1);
    #1 check("R10 nothing extra", {31'd0, out_valid}, 0);
  endtask

  task automatic t_any_slot();
    logic a;
    start(0, 0);
    for (int k = 0; k < 6; k++) enq(1, 16'h400 + 16'(k), 0, a);
    enq(0, 16'hA0, 1, a);
    enq(0, 16'hB0, 0, a);
    deq_expect("R6 ready thread first", 16'hA0, 0);
    #1 check("R7 none issuable", {31'd0, out_valid}, 0);
    wake(4'd7);
    #1 check("R3 slot7 woke", {16'd0, out_payload}, 32'hB0);
    check("R3 valid", {31'd0, out_valid}, 1);
    wake(4'd2);
    #1 check("R6 older wins", {16'd0, out_payload}, 32'h402);
    check("R6 tid", {31'd0, out_tid}, 1);
  endtask

  task automatic t_halves();
    logic a;
    start(1, 0);
    enq(1, 16'hC0, 0, a);
    wake(4'd0);
    #1 check("R7 wake empty", {31'd0, out_valid}, 0);
    wake(4'd6);
    #1 check("R4 slot6", {16'd0, out_payload}, 32'hC0);
    for (int k = 0; k < 6; k++) enq(0, 16'h500 + 16'(k), 1, a);
    check("R4 full", {30'd0, full}, 2'b01);
    enq(0, 16'h5FF, 1, a);
    check("R4 refused", {31'd0, a}, 0);
    enq(1, 16'hC1, 1, a);
    check("R4 t1 accepted", {31'd0, a}, 1);
  endtask

  task automatic t_solo();
    logic a;
    start(0, 1);
    for (int k = 0; k < 12; k++) begin
      enq(0, 16'h600 + 16'(k), 1, a);
      check("R5 accept", {31'd0, a}, 1);
      if (k == 10) check("R5 room left", {30'd0, full}, 0);
    end
    check("R5 full", {30'd0, full}, 2'b11);
    for (int k = 0; k < 12; k++) deq_expect("R5 drain", 16'h600 + 16'(k), 0);
  endtask

  task automatic t_mix();
    logic a;
    start(0, 0);
    enq(0, 16'h700, 1, a); enq(1, 16'h701, 1, a);
    enq(0, 16'h702, 1, a); enq(1, 16'h703, 1, a);
    deq_expect("R6 mix", 16'h700, 0); deq_expect("R6 mix", 16'h701, 1);
    deq_expect("R6 mix", 16'h702, 0); deq_expect("R6 mix", 16'h703, 1);
  endtask

  task automatic t_flush();
    logic a;
    start(0, 0);
    enq(0, 16'h800, 1, a); enq(1, 16'h8C0, 1, a); enq(0, 16'h801, 1, a);
    flush = 2'b01; in_valid = 1; in_tid = 0;
    #1 check("R8 refuse during flush", {31'd0, in_ready}, 0);
    @(posedge clk); #1 flush = 0; in_valid = 0;
    for (int k = 0; k < 6; k++) enq(0, 16'h810 + 16'(k), 0, a);
    check("R8 full before", {30'd0, full}, 2'b01);
    flush = 2'b01;
    @(posedge clk); #1 flush = 0;
    check("R8 full after", {30'd0, full}, 2'b00);
    deq_expect("R8 survivor", 16'h8C0, 1);
    #1 check("R8 empty", {31'd0, out_valid}, 0);
  endtask

  task automatic t_same_cycle();
    logic a;
    start(0, 0);
    for (int k = 0; k < 5; k++) enq(0, 16'h900 + 16'(k), 1, a);
    in_valid = 1; in_tid = 0; in_payload = 16'h9A0; in_issuable = 1;
    out_ready = 1;
    #1 check("R9 ready", {31'd0, in_ready}, 1);
    check("R9 out", {16'd0, out_payload}, 32'h900);
    @(posedge clk); #1 in_valid = 0; out_ready = 0;
    check("R9 not full", {30'd0, full}, 0);
    enq(0, 16'h9B0, 1, a);
    check("R9 full", {30'd0, full}, 2'b01);
    for (int k = 1; k < 5; k++) deq_expect("R9 drain", 16'h900 + 16'(k), 0);
    deq_expect("R9 drain", 16'h9A0, 0);
    deq_expect("R9 drain", 16'h9B0, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cap();
    t_any_slot();
    t_halves();
    t_solo();
    t_mix();
    t_flush();
    t_same_cycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule